// File: doc/BRIEF.md
# Paged Serial Memory Command Front End

This block is the slave side of a serial command port for a memory organised in 264-byte pages (256 data bytes plus 8 spare). The host pulls chip select low, shifts in an 8-bit opcode and then a 24-bit address frame on the serial input, most significant bit first, and then either reads a byte stream back on the serial output or writes a byte stream into the on-chip 264-byte data buffer. The serial clock, chip select and serial input arrive already synchronised to the block's system clock. Edges of the serial clock are found by oversampling.

Two read categories exist, each selected by its own opcode. In the direct category, input bits are taken on rising serial clock edges, output bits change on falling edges, and the first data bit follows the last address bit at once. In the idle-level category, eight don't-care bits follow the address before data starts. Both categories work with the clock idling low or high. Either category can read the data buffer or the main array. The main array is a behavioural stand-in whose contents are a fixed function of page and byte address. Byte addresses run from 0 to 263. A read or write stream steps through them and wraps back to 0 inside the page.

Top module: `pgsf_top`

## Requirements
- R1: A command starts only on a falling edge of `csN` seen after reset. Serial clock and data activity while `csN` is high starts nothing, writes nothing and never enables `misoOe`.
- R2: The first 8 bits after `csN` falls form the opcode, followed by a 24-bit frame, both MSB first. Buffer commands take the byte address from frame bits [8:0]. Main-array commands take the page from bits [18:9] and the byte from bits [8:0]. Bits [23:19] are ignored.
- R3: Direct reads (opcode 0xA5 buffer, 0xB5 main) sample input on rising edges and change `miso` only on falling edges. The first data bit (bit 7 of the first byte) appears after the falling edge that follows the 32nd rising edge. Data is sent MSB first, and `misoOe` stays low before that edge.
- R4: Idle-level reads (opcode 0xA1 buffer, 0xB1 main) ignore 8 bits after the frame. The first data bit appears after the falling edge that follows the 40th rising edge.
- R5: Opcode 0xC3 writes each complete 8-bit group (MSB first) that follows the frame into the buffer at the current byte address, then increments the address, wrapping from 263 to 0.
- R6: A read streams bytes without a break while `csN` stays low. The byte address steps by one and wraps from 263 to 0. A main-array read keeps its page.
- R7: The main-array byte at page p and byte b equals b[7:0] XOR the low 8 bits of the 10-bit value {p[2:0], p[9:3]}. Here p[9:3] is the 8-page block index and p[2:0] is the page within the block.
- R8: A frame whose byte field is 264 to 511 rejects the command. `misoOe` stays low and the buffer is not written.
- R9: An opcode other than 0xA1, 0xA5, 0xB1, 0xB5 or 0xC3 keeps `misoOe` low until `csN` rises. The next command then decodes normally.
- R10: A rise of `csN` at any point aborts the command. A partly shifted write byte is discarded, and the next falling edge of `csN` starts a fresh opcode.
- R11: After reset, and whenever `csN` is high, `misoOe` and `miso` are 0. While `misoOe` is 0, `miso` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select, synchronised |
| sclk | input | 1 | Serial clock, synchronised |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| misoOe | output | 1 | Output enable for `miso`; low means tri-stated |

## Verification
The bench counts falling edges to find the exact edge that first drives data, in both read categories and at both clock idle levels. A design that launched one edge early or late, or that forgot the eight ignored bits, shows the wrong `misoOe` at that index. Streams begin near the end of the page so that a wrap to 0 is crossed. A design that wrapped at 511, or that moved the main-array page while wrapping, returns the wrong bytes. The bench also writes at 262 so that the write pointer crosses the same boundary. Other tests try out-of-range byte fields, unknown opcodes, a clock toggled while deselected, and a write aborted four bits into its second byte. A design that let any of these through either drives the output or corrupts a buffer byte, and a later read exposes the bad byte.

// File: rtl/pgsf_pkg.sv
package pgsf_pkg;

  // Opcode values; bit 2 set marks the direct-timing read category.
  localparam logic [7:0] OP_BUF_RD_LVL = 8'hA1;
  localparam logic [7:0] OP_BUF_RD_DIR = 8'hA5;
  localparam logic [7:0] OP_MEM_RD_LVL = 8'hB1;
  localparam logic [7:0] OP_MEM_RD_DIR = 8'hB5;
  localparam logic [7:0] OP_BUF_WR     = 8'hC3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPCODE,
    ST_ADDR,
    ST_DUMMY,
    ST_RDATA,
    ST_WDATA,
    ST_DEAD
  } ctrlState_t;

  // Strobes from control to datapath, valid for one system clock.
  typedef struct packed {
    logic shiftIn;    // take mosi into the frame shifter
    logic latchAddr;  // last frame bit: load page and byte pointers
    logic readStep;   // falling serial edge during a read
    logic writeByte;  // eighth data bit: store byte into buffer
    logic memSel;     // read source is the main array
    logic quiet;      // deselected: clear output drive
  } strobe_t;

endpackage

// File: rtl/pgsf_ctrl.sv
module pgsf_ctrl
  import pgsf_pkg::*;
#(
  parameter int OP_W       = 8,
  parameter int FRAME_W    = 24,
  parameter int DUMMY_BITS = 8,
  parameter int DATA_W     = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csN,
  input  logic            sclk,
  input  logic [OP_W-1:0] frameOp,
  input  logic            frameByteOk,
  output strobe_t         strb
);

  localparam int CNT_MAX = (FRAME_W > DUMMY_BITS) ? FRAME_W : DUMMY_BITS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] OP_LAST    = CNT_W'(OP_W - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST  = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] DUMMY_LAST = CNT_W'(DUMMY_BITS - 1);
  localparam logic [CNT_W-1:0] WBYTE_LAST = CNT_W'(DATA_W - 1);

  ctrlState_t       state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic             sclkPrev, csPrev;
  logic             isMem, isLvl, isWrite;
  logic             isMemNxt, isLvlNxt, isWriteNxt;
  logic             rise, fall, csFall;
  logic             opKnown, opMem, opLvl, opWr;

  assign rise   = sclk & ~sclkPrev;
  assign fall   = ~sclk & sclkPrev;
  assign csFall = ~csN & csPrev;

  always_comb begin
    opKnown = 1'b1;
    opMem   = 1'b0;
    opLvl   = 1'b0;
    opWr    = 1'b0;
    case (frameOp)
      OP_W'(OP_BUF_RD_LVL): opLvl = 1'b1;
      OP_W'(OP_BUF_RD_DIR): ;
      OP_W'(OP_MEM_RD_LVL): begin opMem = 1'b1; opLvl = 1'b1; end
      OP_W'(OP_MEM_RD_DIR): opMem = 1'b1;
      OP_W'(OP_BUF_WR):     opWr  = 1'b1;
      default:              opKnown = 1'b0;
    endcase
  end

  always_comb begin
    stateNxt    = state;
    cntNxt      = cnt;
    isMemNxt    = isMem;
    isLvlNxt    = isLvl;
    isWriteNxt  = isWrite;
    strb        = '0;
    strb.quiet  = csN;
    strb.memSel = isMem;
    if (csN) begin
      stateNxt = ST_IDLE;
      cntNxt   = '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (csFall) begin
            stateNxt = ST_OPCODE;
            cntNxt   = '0;
          end
        end
        ST_OPCODE: begin
          if (rise) begin
            strb.shiftIn = 1'b1;
            cntNxt       = cnt + 1'b1;
            if (cnt == OP_LAST) begin
              cntNxt     = '0;
              isMemNxt   = opMem;
              isLvlNxt   = opLvl;
              isWriteNxt = opWr;
              stateNxt   = opKnown ? ST_ADDR : ST_DEAD;
            end
          end
        end
        ST_ADDR: begin
          if (rise) begin
            strb.shiftIn = 1'b1;
            cntNxt       = cnt + 1'b1;
            if (cnt == ADDR_LAST) begin
              cntNxt = '0;
              if (!frameByteOk) begin
                stateNxt = ST_DEAD;
              end else begin
                strb.latchAddr = 1'b1;
                if (isWrite)    stateNxt = ST_WDATA;
                else if (isLvl) stateNxt = ST_DUMMY;
                else            stateNxt = ST_RDATA;
              end
            end
          end
        end
        ST_DUMMY: begin
          if (rise) begin
            cntNxt = cnt + 1'b1;
            if (cnt == DUMMY_LAST) begin
              cntNxt   = '0;
              stateNxt = ST_RDATA;
            end
          end
        end
        ST_RDATA: begin
          if (fall) strb.readStep = 1'b1;
        end
        ST_WDATA: begin
          if (rise) begin
            strb.shiftIn = 1'b1;
            cntNxt       = cnt + 1'b1;
            if (cnt == WBYTE_LAST) begin
              cntNxt         = '0;
              strb.writeByte = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sclkPrev <= 1'b0;
      csPrev   <= 1'b0;
      isMem    <= 1'b0;
      isLvl    <= 1'b0;
      isWrite  <= 1'b0;
    end else begin
      state    <= stateNxt;
      cnt      <= cntNxt;
      sclkPrev <= sclk;
      csPrev   <= csN;
      isMem    <= isMemNxt;
      isLvl    <= isLvlNxt;
      isWrite  <= isWriteNxt;
    end
  end

endmodule

// File: rtl/pgsf_dpath.sv
module pgsf_dpath
  import pgsf_pkg::*;
#(
  parameter int PAGE_BYTES = 264,
  parameter int BYTE_AW    = 9,
  parameter int PAGE_AW    = 10,
  parameter int FRAME_W    = 24,
  parameter int OP_W       = 8,
  parameter int BLK_SHIFT  = 3,
  parameter int DATA_W     = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            mosi,
  input  strobe_t         strb,
  output logic [OP_W-1:0] frameOp,
  output logic            frameByteOk,
  output logic            miso,
  output logic            misoOe
);

  localparam logic [BYTE_AW-1:0] LAST_BYTE = BYTE_AW'(PAGE_BYTES - 1);
  localparam int BIT_W = $clog2(DATA_W);

  logic [FRAME_W-1:0] sh, frameNxt;
  logic [BYTE_AW-1:0] byteAddr, nextByte;
  logic [PAGE_AW-1:0] pageAddr, pageRot;
  logic [DATA_W-1:0]  outShift, srcByte, memByte;
  logic [BIT_W-1:0]   outCnt;
  logic [DATA_W-1:0]  bufMem [PAGE_BYTES];

  assign frameNxt    = {sh[FRAME_W-2:0], mosi};
  assign frameOp     = frameNxt[OP_W-1:0];
  assign frameByteOk = (frameNxt[BYTE_AW-1:0] <= LAST_BYTE);
  assign nextByte    = (byteAddr == LAST_BYTE) ? '0 : byteAddr + 1'b1;

  // Behavioural main array: content folds block and in-block page indices.
  generate
    if (BLK_SHIFT > 0) begin : g_rot
      assign pageRot = {pageAddr[BLK_SHIFT-1:0], pageAddr[PAGE_AW-1:BLK_SHIFT]};
    end else begin : g_norot
      assign pageRot = pageAddr;
    end
  endgenerate

  assign memByte = byteAddr[DATA_W-1:0] ^ pageRot[DATA_W-1:0];
  assign srcByte = strb.memSel ? memByte : bufMem[byteAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sh       <= '0;
      byteAddr <= '0;
      pageAddr <= '0;
      outShift <= '0;
      outCnt   <= '0;
      miso     <= 1'b0;
      misoOe   <= 1'b0;
    end else begin
      if (strb.shiftIn) sh <= frameNxt;
      if (strb.latchAddr) begin
        byteAddr <= frameNxt[BYTE_AW-1:0];
        pageAddr <= frameNxt[BYTE_AW +: PAGE_AW];
        outCnt   <= '0;
      end
      if (strb.readStep) begin
        misoOe <= 1'b1;
        outCnt <= outCnt + 1'b1;
        if (outCnt == '0) begin
          miso     <= srcByte[DATA_W-1];
          outShift <= {srcByte[DATA_W-2:0], 1'b0};
          byteAddr <= nextByte;
        end else begin
          miso     <= outShift[DATA_W-1];
          outShift <= {outShift[DATA_W-2:0], 1'b0};
        end
      end
      if (strb.writeByte) byteAddr <= nextByte;
      if (strb.quiet) begin
        miso   <= 1'b0;
        misoOe <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.writeByte) bufMem[byteAddr] <= frameNxt[DATA_W-1:0];
  end

endmodule

// File: rtl/pgsf_top.sv
module pgsf_top
  import pgsf_pkg::*;
#(
  parameter int PAGE_BYTES = 264,
  parameter int BYTE_AW    = 9,
  parameter int PAGE_AW    = 10,
  parameter int FRAME_W    = 24,
  parameter int OP_W       = 8,
  parameter int DUMMY_BITS = 8,
  parameter int BLK_SHIFT  = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic mosi,
  output logic miso,
  output logic misoOe
);

  localparam int DATA_W = 8;

  strobe_t         strb;
  logic [OP_W-1:0] frameOp;
  logic            frameByteOk;

  pgsf_ctrl #(
    .OP_W(OP_W), .FRAME_W(FRAME_W), .DUMMY_BITS(DUMMY_BITS), .DATA_W(DATA_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk),
    .frameOp(frameOp), .frameByteOk(frameByteOk), .strb(strb)
  );

  pgsf_dpath #(
    .PAGE_BYTES(PAGE_BYTES), .BYTE_AW(BYTE_AW), .PAGE_AW(PAGE_AW),
    .FRAME_W(FRAME_W), .OP_W(OP_W), .BLK_SHIFT(BLK_SHIFT), .DATA_W(DATA_W)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .mosi(mosi), .strb(strb),
    .frameOp(frameOp), .frameByteOk(frameByteOk),
    .miso(miso), .misoOe(misoOe)
  );

endmodule

// File: rtl/pgsf_checker.sv
module pgsf_checker (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sclk,
  input logic miso,
  input logic misoOe
);

  // R11: deselect silences the output on the next clock
  a_r11_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !misoOe);

  // R11: no data level without enable
  a_r11_low_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !misoOe |-> !miso);

  // R1: enable never rises out of a deselected cycle
  a_r1_drive_needs_select: assert property (@(posedge clk) disable iff (!rstN)
    $rose(misoOe) |-> !$past(csN));

  // R3: output enable turns on only at a falling serial edge
  a_r3_enable_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $rose(misoOe) |-> ($past(sclk, 2) && !$past(sclk)));

  // R3: while driving, data changes only after a falling serial edge
  a_r3_change_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    ($past(misoOe) && !$past(csN) && (miso != $past(miso)))
      |-> ($past(sclk, 2) && !$past(sclk)));

endmodule

bind pgsf_top pgsf_checker chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .miso(miso), .misoOe(misoOe)
);

// File: tb/pgsf_top_tb_top.sv
module pgsf_top_tb_top;

  localparam int NB     = 264;
  localparam int MAXB   = 2400;
  localparam int HALF   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic miso, misoOe;

  int nChecks = 0;
  int nFails  = 0;

  logic [7:0] model [NB];
  logic [7:0] wq    [300];
  bit         rxB   [MAXB];
  bit         oeB   [MAXB];

  always #5 clk = ~clk;

  pgsf_top dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
    .miso(miso), .misoOe(misoOe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R7 content rule
  function automatic logic [7:0] memExp(input logic [9:0] p, input logic [8:0] b);
    logic [9:0] r;
    r = {p[2:0], p[9:3]};
    return b[7:0] ^ r[7:0];
  endfunction

  function automatic int wrapNext(input int a);
    return (a == NB - 1) ? 0 : a + 1;
  endfunction

  // Runs one select window with nBits clocked bits; records miso/oe after each falling edge.
  task automatic runCmd(input logic [7:0] op, input logic [23:0] frame,
                        input int nBits, input bit idleHigh);
    sclk = idleHigh;
    waitN(HALF);
    csN = 1'b0;
    waitN(HALF);
    if (idleHigh) begin
      sclk = 1'b0;
      waitN(HALF);
    end
    for (int i = 0; i < nBits; i++) begin
      if (i < 8)       mosi = op[7 - i];
      else if (i < 32) mosi = frame[31 - i];
      else             mosi = wq[(i - 32) / 8][7 - ((i - 32) % 8)];
      sclk = 1'b1;
      waitN(HALF);
      sclk = 1'b0;
      waitN(HALF);
      rxB[i] = miso;
      oeB[i] = misoOe;
    end
    if (idleHigh) begin
      sclk = 1'b1;
      waitN(HALF);
    end
    csN = 1'b1;
    waitN(HALF);
    check(!misoOe && !miso, "R11", {misoOe, miso}, 0);
    sclk = 1'b0;
    mosi = 1'b0;
  endtask

  task automatic writeBuf(input int start, input int n, input bit idleHigh);
    int a;
    runCmd(8'hC3, 24'(start), 32 + 8 * n, idleHigh);
    a = start;
    for (int k = 0; k < n; k++) begin
      model[a] = wq[k];
      a = wrapNext(a);
    end
  endtask

  task automatic readChk(input bit isMem, input bit lvl, input bit idleHigh,
                         input logic [9:0] page, input int start, input int n,
                         input string req);
    logic [7:0] op;
    logic [23:0] frame;
    int first, a;
    logic [7:0] got, exp;
    op    = isMem ? (lvl ? 8'hB1 : 8'hB5) : (lvl ? 8'hA1 : 8'hA5);
    frame = isMem ? {5'h15, page, 9'(start)} : {15'h5A5A, 9'(start)};
    first = lvl ? 39 : 31;
    runCmd(op, frame, first + 1 + 8 * n, idleHigh);
    // R3 / R4: exact launch edge
    check(!oeB[first - 1] && oeB[first], lvl ? "R4" : "R3",
          {oeB[first - 1], oeB[first]}, 1);
    a = start;
    for (int k = 0; k < n; k++) begin
      for (int j = 0; j < 8; j++) got[7 - j] = rxB[first + 8 * k + j];
      exp = isMem ? memExp(page, 9'(a)) : model[a];
      check(got === exp, req, got, exp);
      a = wrapNext(a);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_2024));
    waitN(3);
    // R11: reset state
    check(!misoOe && !miso, "R11", {misoOe, miso}, 0);
    rstN = 1'b1;
    waitN(3);
    check(!misoOe && !miso, "R11", {misoOe, miso}, 0);

    // R5: fill the whole buffer
    for (int k = 0; k < NB; k++) wq[k] = 8'($urandom);
    writeBuf(0, NB, 1'b0);
    // R2: buffer address in low frame bits, upper bits ignored
    readChk(1'b0, 1'b0, 1'b0, 10'h0, 17, 4, "R2");
    // R5: write pointer wraps 263 -> 0
    wq[0] = 8'h3C; wq[1] = 8'hC3; wq[2] = 8'h99;
    writeBuf(262, 3, 1'b1);
    readChk(1'b0, 1'b0, 1'b0, 10'h0, 262, 3, "R5");
    // R6: read stream wraps
    readChk(1'b0, 1'b0, 1'b1, 10'h0, 260, 8, "R6");
    // R4: idle-level category, both idle levels
    readChk(1'b0, 1'b1, 1'b1, 10'h0, 100, 3, "R4");
    readChk(1'b0, 1'b1, 1'b0, 10'h0, 263, 2, "R4");
    // R7 / R6: main array, wrap inside page keeps page
    readChk(1'b1, 1'b0, 1'b0, 10'h3FF, 261, 5, "R7");
    readChk(1'b1, 1'b1, 1'b1, 10'h155, 0, 3, "R7");
    readChk(1'b1, 1'b0, 1'b1, 10'h20B, 259, 7, "R6");

    // R1: activity while deselected does nothing
    begin
      logic [39:0] pat;
      bit sawOe;
      pat = {8'hC3, 24'd7, ~model[7]};
      sawOe = 1'b0;
      csN = 1'b1;
      for (int i = 0; i < 40; i++) begin
        mosi = pat[39 - i];
        sclk = 1'b1; waitN(HALF);
        sclk = 1'b0; waitN(HALF);
        sawOe |= misoOe;
      end
      check(!sawOe, "R1", sawOe, 0);
      readChk(1'b0, 1'b0, 1'b0, 10'h0, 7, 1, "R1");
    end

    // R8: out-of-range byte field
    runCmd(8'hA5, 24'd300, 32 + 16, 1'b0);
    begin
      bit any;
      any = 1'b0;
      for (int i = 0; i < 48; i++) any |= oeB[i];
      check(!any, "R8", any, 0);
    end
    wq[0] = 8'h00; wq[1] = 8'hFF;
    runCmd(8'hC3, 24'd270, 32 + 16, 1'b0);
    readChk(1'b0, 1'b0, 1'b0, 10'h0, 0, 16, "R8");

    // R9: unknown opcode stays silent, next command decodes
    runCmd(8'h00, 24'd5, 48, 1'b0);
    begin
      bit any;
      any = 1'b0;
      for (int i = 0; i < 48; i++) any |= oeB[i];
      check(!any, "R9", any, 0);
    end
    readChk(1'b0, 1'b0, 1'b0, 10'h0, 40, 2, "R9");

    // R10: abort mid-byte discards the partial byte
    wq[0] = ~model[5]; wq[1] = ~model[6];
    runCmd(8'hC3, 24'd5, 32 + 12, 1'b0);
    model[5] = wq[0];
    readChk(1'b0, 1'b0, 1'b0, 10'h0, 5, 2, "R10");
    // R10: abort during a read, then a fresh command
    runCmd(8'hA5, 24'd50, 36, 1'b0);
    check(!misoOe, "R10", misoOe, 0);
    readChk(1'b0, 1'b1, 1'b0, 10'h0, 51, 2, "R10");

    // Random mix
    for (int it = 0; it < 24; it++) begin
      int kind, st, n;
      bit lvl, ih;
      kind = $urandom_range(0, 2);
      st   = $urandom_range(0, NB - 1);
      n    = $urandom_range(1, 10);
      lvl  = 1'($urandom);
      ih   = 1'($urandom);
      if (kind == 0) begin
        readChk(1'b0, lvl, ih, 10'h0, st, n, lvl ? "R4" : "R3");
      end else if (kind == 1) begin
        readChk(1'b1, lvl, ih, 10'($urandom), st, n, "R7");
      end else begin
        for (int k = 0; k < n; k++) wq[k] = 8'($urandom);
        writeBuf(st, n, ih);
        readChk(1'b0, 1'b0, 1'b0, 10'h0, st, n, "R5");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule